// File: doc/BRIEF.md
# Fractional Clock-Enable Divider

This block turns the system clock into a train of single-cycle enable pulses whose average spacing is a programmable integer number of cycles plus a fraction in steps of 1/256. The pulse is meant to qualify logic that runs slower than the system clock. No second clock is made.

A down-counter measures out each period. An 8-bit phase accumulator adds the fractional part once per period. When that addition carries out, the following period is one cycle longer. Over many periods the mean spacing is therefore the integer part plus the fractional part divided by 256. Two further inputs control the train. One pauses it without losing its place. The other starts it again from a known phase: both the counter and the accumulator go back to their start values. If several copies receive the restart in the same cycle and are given the same divisor, their pulse trains match exactly from then on.

Top module: `frac_clk_en_div`

## Requirements
- R1: While `rst_n` is low, `tick` is 0. After reset is released, `tick` is 1 on the first cycle with `run` high. After that, pulses follow the rule in R4.
- R2: With `div_frac` = 0 and `div_int` = N > 1, pulses are exactly N enabled cycles apart, and each pulse lasts one cycle.
- R3: A `div_int` value of 0 selects a period of 65536 cycles (2^INT_W).
- R4: Count enabled cycles from c = 0, the first enabled cycle after a restart or reset. `tick` is high exactly at c = k*N + floor(k*F/256) for k = 0, 1, 2, and so on. Here N is the effective integer part and F is `div_frac`. This gives an average period of N + F/256.
- R5: With `div_int` = 1 and `div_frac` = 0, `tick` is high on every enabled cycle.
- R6: In a cycle where `restart` is high, `tick` is 0. That cycle clears the period counter and the phase accumulator. `tick` then rises on the next cycle in which `run` is high.
- R7: Two dividers with different histories produce identical pulse trains from then on, provided they are restarted in the same cycle and given the same divisor.
- R8: The values of `div_int` and `div_frac` are sampled in the cycle that `tick` is high, and they define the period that follows. A change made in the middle of a period does not alter that period.
- R9: While `run` is low, `tick` stays 0 and the counter and accumulator hold their values. Counting resumes from the same point when `run` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Enables counting; when low the divider pauses |
| restart | input | 1 | Clears the period counter and phase accumulator |
| div_int | input | 16 | Integer part of the divisor; 0 means 65536 |
| div_frac | input | 8 | Fractional part of the divisor in 1/256 steps |
| tick | output | 1 | Single-cycle enable pulse |

## Verification
The bench sweeps integer parts 1 to 6 against fractional parts that include 0, 1, 128 and 255. It compares every cycle with the closed form k*N + floor(k*F/256). An accumulator that dropped its carry, or added the carry to the wrong period, would move a pulse by one cycle within the first few periods. The bench also runs one full period with an integer part of 0. A design that treated 0 as 1, or as 65535, would pulse every cycle or one cycle early. Further checks change the divisor in the middle of a period, which catches a design that applies the new value at once rather than at the next boundary. They pause `run` partway through a train, which catches a counter that keeps running while paused. They restart two dividers that were out of phase and require identical trains afterwards, which catches a restart that leaves the fractional phase behind.

// File: rtl/frac_div_pkg.sv
// Package: shared helpers for the fractional clock-enable divider.
// Assumes integer-part widths of at most 31 bits.
package frac_div_pkg;

    // Turns a programmed integer part into the period length it stands for.
    function automatic logic [31:0] span_of(input logic [31:0] int_val, input int unsigned int_w);
        if (int_val == 32'd0)
            return 32'd1 << int_w;
        else
            return int_val;
    endfunction

endpackage

// File: rtl/frac_phase_acc.sv
// Module: frac_phase_acc
// Holds the fractional phase of the divider. Each step adds the fractional
// input, and the carry out is offered combinationally so that the boundary
// which consumes it can lengthen the next period.
// Assumes clear has priority over step.
module frac_phase_acc #(
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac,
    output logic              carry
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    // Adds the fraction to the held phase, keeping the carry bit.
    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, frac};
        carry = sum[FRAC_W];
    end

    // Keeps the phase: clears on reset or restart, advances on each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (clear)
            acc_q <= '0;
        else if (step)
            acc_q <= sum[FRAC_W-1:0];
    end

    // R6: a restart leaves the phase at zero.
    p_acc_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc_q == '0));

    // R4: a carry wraps the phase downward; without one it never decreases.
    p_carry_wraps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && carry) |=> (acc_q < $past(acc_q)));
    p_no_carry_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && !carry) |=> (acc_q >= $past(acc_q)));

    // R9: with no step and no clear the phase is held.
    p_phase_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(acc_q));
endmodule

// File: rtl/span_select.sv
// Module: span_select
// Builds the length of the next period from the integer input and the
// carry of the phase accumulator. An integer of zero stands for the
// largest span, 2^INT_W.
// Assumes CNT_W is at least INT_W + 1 so that the longest span plus one fits.
module span_select #(
    parameter int INT_W = 16,
    parameter int CNT_W = INT_W + 1
) (
    input  logic [INT_W-1:0] div_int,
    input  logic             carry,
    output logic [CNT_W-1:0] span
);
    logic [CNT_W-1:0] base_len;

    // Maps the programmed integer to a span and adds the extra carry cycle.
    always_comb begin
        base_len = CNT_W'(frac_div_pkg::span_of(32'(div_int), INT_W));
        span     = base_len + CNT_W'(carry);
    end

    // R3: the span is never zero and never beyond 2^INT_W + 1.
    always_comb begin
        a_span_range_r3: assert (span != '0 && span <= ((CNT_W'(1) << INT_W) + CNT_W'(1)));
    end
endmodule

// File: rtl/period_down_counter.sv
// Module: period_down_counter
// Counts down the cycles left in the current period. It flags the last
// cycle, and on that cycle it reloads with the span offered at its input.
// Assumes the offered span is never zero.
module period_down_counter #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [CNT_W-1:0] load_len,
    output logic             at_end
);
    logic [CNT_W-1:0] left_q;

    // Marks the final cycle of the running period.
    always_comb at_end = (left_q == CNT_W'(1));

    // Keeps the count: restart puts the boundary on the next enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= CNT_W'(1);
        else if (clear)
            left_q <= CNT_W'(1);
        else if (advance) begin
            if (at_end)
                left_q <= load_len;
            else
                left_q <= left_q - CNT_W'(1);
        end
    end

    // R6: a restart leaves exactly one cycle before the next boundary.
    p_count_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (left_q == CNT_W'(1)));

    // R9: when paused the count does not move.
    p_count_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !clear) |=> $stable(left_q));

    // R2: the count never reaches zero.
    p_count_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        left_q != '0);
endmodule

// File: rtl/frac_clk_en_div.sv
// Module: frac_clk_en_div
// Top of the fractional clock-enable divider. It emits one-cycle pulses
// whose average spacing is div_int + div_frac/256 enabled cycles. The
// divisor is sampled on each pulse and sets the following period.
// Assumes restart and run come from logic in the same clock domain.
module frac_clk_en_div #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              tick
);
    localparam int CNT_W = INT_W + 1;

    logic             carry;
    logic             at_end;
    logic [CNT_W-1:0] next_span;

    // Pulses on the final cycle of a period if running and not restarting.
    always_comb tick = rst_n & run & ~restart & at_end;

    frac_phase_acc #(.FRAC_W(FRAC_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart),
        .step  (tick),
        .frac  (div_frac),
        .carry (carry)
    );

    span_select #(.INT_W(INT_W), .CNT_W(CNT_W)) u_span (
        .div_int (div_int),
        .carry   (carry),
        .span    (next_span)
    );

    period_down_counter #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (restart),
        .advance  (run),
        .load_len (next_span),
        .at_end   (at_end)
    );

    // R9: no pulse while paused.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);

    // R6: no pulse in the restart cycle, and a pulse on the next running cycle.
    p_restart_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> !tick);
    p_restart_then_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(restart) && run && !restart) |-> tick);

    // R5: a unit divisor with no fraction pulses on every running cycle.
    p_unit_divisor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_int == INT_W'(1) && div_frac == '0) ##1 (run && !restart) |-> tick);

    // R2: a pulse with a divisor above one is followed by a quiet cycle.
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_int > INT_W'(1)) |=> !tick);
endmodule

// File: tb/frac_clk_en_div_test.sv
// Bench: sweeps small divisors against the closed-form pulse positions.
module frac_clk_en_div_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        restart = 1'b0;
    logic [15:0] dint = 16'd4;
    logic [7:0]  dfrac = 8'd0;
    logic        restart_b = 1'b0;
    logic [15:0] dint_b = 16'd7;
    logic [7:0]  dfrac_b = 8'd0;
    logic        tick;
    logic        tick_b;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    frac_clk_en_div uut (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
        .div_int(dint), .div_frac(dfrac), .tick(tick)
    );

    frac_clk_en_div uut_b (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart_b),
        .div_int(dint_b), .div_frac(dfrac_b), .tick(tick_b)
    );

    task automatic check(input logic got, input logic exp, input string req, input longint c);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: tick=%b expected %b at cycle %0d", req, got, exp, c);
        end
    endtask

    function automatic logic expect_at(input longint c, input longint n, input longint f, inout longint k);
        if (c == k * n + (k * f) / 256) begin
            k++;
            return 1'b1;
        end
        return 1'b0;
    endfunction

    // Restarts, then checks every cycle; optionally pauses run at one point.
    task automatic train(input int n, input int f, input int cycles,
                         input int gap_at, input int gap_len, input string req);
        longint neff = (n == 0) ? 65536 : n;
        longint k = 0;
        @(negedge clk);
        dint = 16'(n); dfrac = 8'(f); run = 1'b1; restart = 1'b1;
        #2 check(tick, 1'b0, "R6", -1);
        @(negedge clk);
        restart = 1'b0;
        for (int c = 0; c < cycles; c++) begin
            if (c == gap_at) begin
                run = 1'b0;
                for (int g = 0; g < gap_len; g++) begin
                    #2 check(tick, 1'b0, "R9", c);
                    @(negedge clk);
                end
                run = 1'b1;
            end
            #2 check(tick, expect_at(c, neff, f, k), req, c);
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int fr[6] = '{0, 1, 64, 128, 200, 255};
        // R1: quiet during reset, then a pulse on the first running cycle.
        run = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #2 check(tick, 1'b0, "R1", i);
        end
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 12; c++) begin
            #2 check(tick, (c % 4) == 0, "R1", c);
            @(negedge clk);
        end

        // R2, R4, R5: sweep of small integer and fractional parts.
        for (int n = 1; n <= 6; n++) begin
            for (int j = 0; j < 6; j++) begin
                string req = (fr[j] == 0) ? ((n == 1) ? "R5" : "R2") : "R4";
                train(n, fr[j], 14 * (n + 1), -1, 0, req);
            end
        end

        // R9: pauses in the middle of fractional and unit trains.
        train(3, 77, 60, 10, 4, "R9");
        train(1, 0, 20, 5, 3, "R9");
        train(5, 200, 80, 23, 7, "R9");

        // R8: divisor changed mid-period takes effect after the next pulse.
        @(negedge clk);
        dint = 16'd5; dfrac = 8'd0; restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        for (int c = 0; c < 21; c++) begin
            if (c == 7) dint = 16'd3;
            #2 check(tick, (c == 0 || c == 5 || c == 10 || (c > 10 && (c - 10) % 3 == 0)), "R8", c);
            @(negedge clk);
        end

        // R7: two dividers with different histories line up after a joint restart.
        begin
            longint k = 0;
            @(negedge clk);
            restart_b = 1'b1; dint_b = 16'd3; dfrac_b = 8'd50;
            dint = 16'd5; dfrac = 8'd200;
            @(negedge clk);
            restart_b = 1'b0;
            repeat (23) @(negedge clk);
            restart = 1'b1; restart_b = 1'b1;
            dint = 16'd6; dfrac = 8'd99; dint_b = 16'd6; dfrac_b = 8'd99;
            @(negedge clk);
            restart = 1'b0; restart_b = 1'b0;
            for (int c = 0; c < 150; c++) begin
                logic e;
                e = expect_at(c, 6, 99, k);
                #2;
                check(tick, e, "R7", c);
                check(tick_b, e, "R7", c);
                @(negedge clk);
            end
        end

        // R3: zero integer part gives a 65536-cycle period.
        train(0, 0, 65540, -1, 0, "R3");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule